// File: doc/BRIEF.md
# Cartridge Image Load/Unload Bridge

This block moves a disk cartridge image between a narrow host-processor slave port and a wide memory master port. The host side is 32 bits wide and each access carries two 16-bit words of the emulated machine. The memory side is 64 bits wide, so one memory word holds the contents of two host accesses. The image lives in a reserved region at the very top of memory. That region is 1 MiB by default, which is 131072 memory words.

The host port has four 32-bit word slots. The lower two slots form the control window. Software writes a command there and reads status back. The upper two slots form the data window. To load an image, software issues a load command and then streams writes into the data window. The block keeps the first word of each pair and sends the pair to memory as one 64-bit write when the second word arrives. To unload, software issues an unload command. The block prefetches one 64-bit memory word and hands it out as two 32-bit reads of the data window. The memory address steps through the region by itself.

Status shows busy until the last memory word has been committed or handed out, and only then shows done. The host can therefore poll for completion without losing sync with the block. While a memory access for the current pair is in flight, a data-window access is held off with a wait-request.

Top module: `cart_xfer_bridge`

## Requirements
- R1: The host word address `h_waddr` selects the slot. Slot 0 takes command writes and returns status on read. Slot 1 reads as zero and ignores writes. Slots 2 and 3 are both the data port. The status word has busy in bit 0, done in bit 1 and error in bit 2, and all other bits are zero.
- R2: Command bits [1:0] written to slot 0 are decoded as follows: 1 = load, 2 = unload, 3 = abort, 0 = no effect. A load or unload sets busy, clears done and error, resets the pair phase and moves the memory address to the region base. An abort clears busy and done and stops the transfer.
- R3: During a load, the first data write of a pair goes to memory bits [31:0] and the second goes to bits [63:32]. Each complete pair produces exactly one memory write.
- R4: During an unload, the first data read of a pair returns memory bits [31:0] and the second returns bits [63:32].
- R5: Every memory access falls in the region that starts at base = 2^MEM_AW − IMG_WORDS. The first access of a transfer is at base, and each later access is one memory word above the one before it.
- R6: Busy stays set until the final memory write of a load has been accepted, or until the upper half of the final unload word has been read. Busy then clears and done is set in the same cycle. Busy and done are never set together.
- R7: A data-port access is held with `h_waitreq` while a memory access for the current pair is outstanding. No host word is lost or duplicated across stalls.
- R8: A data-port access made while no transfer is busy has the following effects. A write causes no memory write. A read returns zero. The error status bit is set.
- R9: A memory request held off by `m_waitreq` keeps its address and write data stable until it is accepted. A read and a write are never requested in the same cycle.
- R10: After reset, status reads zero and no memory request is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_waddr | input | 2 | Host word address (byte offset / 4) |
| h_write | input | 1 | Host write strobe |
| h_read | input | 1 | Host read strobe |
| h_wdata | input | 32 | Host write data |
| h_rdata | output | 32 | Host read data, valid when a read is not held |
| h_waitreq | output | 1 | Host access held while high |
| m_addr | output | MEM_AW | Memory word address |
| m_write | output | 1 | Memory write request |
| m_read | output | 1 | Memory read request |
| m_wdata | output | 64 | Memory write data |
| m_rdata | input | 64 | Memory read data |
| m_waitreq | input | 1 | Memory holds off the current request |
| m_rvalid | input | 1 | Memory read data valid |

## Verification
The hardest situation to reach is a host data access that arrives while the previous pair's memory access has not yet completed. This can happen because a memory write is still waiting on `m_waitreq`, or because a prefetch read has not yet returned. The bench's memory model asserts `m_waitreq` at random with high probability and returns read data after a random latency of one to three cycles. The host stream runs back to back, so stalls occur naturally, and the bench confirms that stalls did occur. Directed cases cover the rest: reading status right after the final pair, aborting with half a pair buffered and then restarting, and touching the data port while the block is idle.

// File: rtl/cxb_pkg.sv
package cxb_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_LOAD   = 2'd1,
    MODE_UNLOAD = 2'd2
  } mode_e;

  localparam logic [1:0] CMD_LOAD   = 2'd1;
  localparam logic [1:0] CMD_UNLOAD = 2'd2;
  localparam logic [1:0] CMD_ABORT  = 2'd3;

  typedef struct packed {
    logic cmd_wr;
    logic stat_rd;
    logic data_wr;
    logic data_rd;
  } hsel_t;

  function automatic hsel_t decode_slot(input logic [1:0] slot,
                                        input logic wr, input logic rd);
    hsel_t s;
    s.cmd_wr  = wr && (slot == 2'd0);
    s.stat_rd = rd && (slot == 2'd0);
    s.data_wr = wr && slot[1];
    s.data_rd = rd && slot[1];
    return s;
  endfunction

endpackage

// File: rtl/cxb_host_decode.sv
module cxb_host_decode
  import cxb_pkg::*;
(
  input  logic [1:0] h_waddr,
  input  logic       h_write,
  input  logic       h_read,
  input  logic [1:0] cmd_bits,
  output hsel_t      sel,
  output logic       start_ld,
  output logic       start_ul,
  output logic       do_abort
);
  always_comb begin
    sel      = decode_slot(h_waddr, h_write, h_read);
    start_ld = sel.cmd_wr && (cmd_bits == CMD_LOAD);
    start_ul = sel.cmd_wr && (cmd_bits == CMD_UNLOAD);
    do_abort = sel.cmd_wr && (cmd_bits == CMD_ABORT);
  end
endmodule

// File: rtl/cxb_addr_ctr.sv
module cxb_addr_ctr #(
  parameter int MEM_AW    = 24,
  parameter int IMG_WORDS = 131072
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              step,
  output logic [MEM_AW-1:0] addr,
  output logic              last
);
  localparam int CNT_W = (IMG_WORDS > 1) ? $clog2(IMG_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(IMG_WORDS - 1);

  function automatic logic [MEM_AW-1:0] region_addr(input logic [CNT_W-1:0] idx);
    logic [MEM_AW:0] top;
    top = (MEM_AW+1)'(1) << MEM_AW;
    return MEM_AW'(top - (MEM_AW+1)'(IMG_WORDS)) + MEM_AW'(idx);
  endfunction

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (step && (cnt_q != LAST_IDX)) cnt_q <= cnt_q + 1'b1;
  end

  assign addr = region_addr(cnt_q);
  assign last = (cnt_q == LAST_IDX);
endmodule

// File: rtl/cxb_pair_buf.sv
module cxb_pair_buf #(
  parameter int HW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            ld_lo,
  input  logic            ld_hi,
  input  logic            advance,
  input  logic            fill,
  input  logic [HW-1:0]   din,
  input  logic [2*HW-1:0] fill_din,
  output logic            phase,
  output logic [2*HW-1:0] word,
  output logic [HW-1:0]   half
);
  logic [HW-1:0] lo_q, hi_q;

  function automatic logic [HW-1:0] pick_half(input logic [2*HW-1:0] w, input logic upper);
    return upper ? w[2*HW-1:HW] : w[HW-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= 1'b0;
    else if (restart) phase <= 1'b0;
    else if (advance) phase <= ~phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (fill) begin
      lo_q <= fill_din[HW-1:0];
      hi_q <= fill_din[2*HW-1:HW];
    end else begin
      if (ld_lo) lo_q <= din;
      if (ld_hi) hi_q <= din;
    end
  end

  assign word = {hi_q, lo_q};
  assign half = pick_half(word, phase);
endmodule

// File: rtl/cart_xfer_bridge.sv
module cart_xfer_bridge
  import cxb_pkg::*;
#(
  parameter int HOST_DW   = 32,
  parameter int MEM_AW    = 24,
  parameter int IMG_WORDS = 131072
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           h_waddr,
  input  logic                 h_write,
  input  logic                 h_read,
  input  logic [HOST_DW-1:0]   h_wdata,
  output logic [HOST_DW-1:0]   h_rdata,
  output logic                 h_waitreq,
  output logic [MEM_AW-1:0]    m_addr,
  output logic                 m_write,
  output logic                 m_read,
  output logic [2*HOST_DW-1:0] m_wdata,
  input  logic [2*HOST_DW-1:0] m_rdata,
  input  logic                 m_waitreq,
  input  logic                 m_rvalid
);
  localparam int MEM_DW = 2 * HOST_DW;

  function automatic logic [HOST_DW-1:0] status_word(input logic b, input logic d, input logic e);
    return {{(HOST_DW-3){1'b0}}, e, d, b};
  endfunction

  mode_e mode_q;
  logic  done_q, err_q, pend_q, mwr_q, mrd_q, rdw_q;
  hsel_t sel;
  logic  start_ld, start_ul, do_abort, cancel;
  logic  phase, last, busy;
  logic  wr_ok, rd_ok, idle_acc, data_acc;
  logic  mem_wr_done, mem_rd_acc, mem_rd_done, step, last_commit;
  logic [MEM_DW-1:0]  pair_word;
  logic [HOST_DW-1:0] pair_half;

  cxb_host_decode u_dec (
    .h_waddr (h_waddr), .h_write(h_write), .h_read(h_read),
    .cmd_bits(h_wdata[1:0]), .sel(sel),
    .start_ld(start_ld), .start_ul(start_ul), .do_abort(do_abort)
  );

  assign busy     = (mode_q != MODE_IDLE);
  assign cancel   = start_ld || start_ul || do_abort;
  assign data_acc = sel.data_wr || sel.data_rd;
  assign wr_ok    = sel.data_wr && (mode_q == MODE_LOAD) && !pend_q;
  assign rd_ok    = sel.data_rd && (mode_q == MODE_UNLOAD) && !pend_q;
  assign idle_acc = data_acc && !busy;

  assign mem_wr_done = mwr_q && !m_waitreq;
  assign mem_rd_acc  = mrd_q && !m_waitreq;
  assign mem_rd_done = rdw_q && m_rvalid;
  assign step        = !cancel && (mem_wr_done || (rd_ok && phase));
  assign last_commit = step && last;

  cxb_addr_ctr #(.MEM_AW(MEM_AW), .IMG_WORDS(IMG_WORDS)) u_ctr (
    .clk(clk), .rst_n(rst_n), .restart(start_ld || start_ul),
    .step(step), .addr(m_addr), .last(last)
  );

  cxb_pair_buf #(.HW(HOST_DW)) u_buf (
    .clk(clk), .rst_n(rst_n), .restart(start_ld || start_ul),
    .ld_lo(wr_ok && !phase), .ld_hi(wr_ok && phase),
    .advance(wr_ok || rd_ok), .fill(mem_rd_done && !cancel),
    .din(h_wdata), .fill_din(m_rdata),
    .phase(phase), .word(pair_word), .half(pair_half)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_IDLE;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      pend_q <= 1'b0;
      mwr_q  <= 1'b0;
      mrd_q  <= 1'b0;
      rdw_q  <= 1'b0;
    end else if (do_abort) begin
      mode_q <= MODE_IDLE;
      done_q <= 1'b0;
      pend_q <= 1'b0;
      mwr_q  <= 1'b0;
      mrd_q  <= 1'b0;
      rdw_q  <= 1'b0;
    end else if (start_ld || start_ul) begin
      mode_q <= start_ld ? MODE_LOAD : MODE_UNLOAD;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      mwr_q  <= 1'b0;
      rdw_q  <= 1'b0;
      mrd_q  <= start_ul;
      pend_q <= start_ul;
    end else begin
      if (idle_acc) err_q <= 1'b1;
      if (wr_ok && phase) begin
        mwr_q  <= 1'b1;
        pend_q <= 1'b1;
      end
      if (mem_wr_done) begin
        mwr_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (mem_rd_acc) begin
        mrd_q <= 1'b0;
        rdw_q <= 1'b1;
      end
      if (mem_rd_done) begin
        rdw_q  <= 1'b0;
        pend_q <= 1'b0;
      end
      if (rd_ok && phase && !last) begin
        mrd_q  <= 1'b1;
        pend_q <= 1'b1;
      end
      if (last_commit) begin
        mode_q <= MODE_IDLE;
        done_q <= 1'b1;
      end
    end
  end

  assign m_write   = mwr_q;
  assign m_read    = mrd_q;
  assign m_wdata   = pair_word;
  assign h_waitreq = data_acc && pend_q;

  always_comb begin
    h_rdata = '0;
    if (sel.stat_rd)     h_rdata = status_word(busy, done_q, err_q);
    else if (rd_ok)      h_rdata = pair_half;
  end
endmodule

// File: rtl/cxb_checker.sv
module cxb_checker #(
  parameter int MEM_AW    = 24,
  parameter int IMG_WORDS = 131072,
  parameter int MEM_DW    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              m_write,
  input logic              m_read,
  input logic              m_waitreq,
  input logic [MEM_AW-1:0] m_addr,
  input logic [MEM_DW-1:0] m_wdata,
  input logic              h_waitreq,
  input logic              pend,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              idle_acc,
  input logic              cancel,
  input logic              last_commit
);
  localparam logic [MEM_AW:0] TOP  = (MEM_AW+1)'(1) << MEM_AW;
  localparam logic [MEM_AW-1:0] BASE = MEM_AW'(TOP - (MEM_AW+1)'(IMG_WORDS));

  assert_rw_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_write && m_read));

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write && m_waitreq && !cancel) |=> (m_write && $stable(m_addr) && $stable(m_wdata)));

  assert_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_write || m_read) |-> (m_addr >= BASE));

  assert_status_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_done_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_commit));

  assert_stall_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    h_waitreq |-> (pend && busy));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(idle_acc));
endmodule

bind cart_xfer_bridge cxb_checker #(
  .MEM_AW(MEM_AW), .IMG_WORDS(IMG_WORDS), .MEM_DW(2*HOST_DW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .m_write(m_write), .m_read(m_read),
  .m_waitreq(m_waitreq), .m_addr(m_addr), .m_wdata(m_wdata),
  .h_waitreq(h_waitreq), .pend(pend_q), .busy(busy), .done(done_q),
  .err(err_q), .idle_acc(idle_acc), .cancel(cancel), .last_commit(last_commit)
);

// File: tb/cart_xfer_bridge_tb.sv
`timescale 1ns/1ps
module cart_xfer_bridge_tb;
  localparam int AW  = 10;
  localparam int IMG = 16;
  localparam int BASE = (1 << AW) - IMG;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  h_waddr = '0;
  logic        h_write = 1'b0, h_read = 1'b0;
  logic [31:0] h_wdata = '0, h_rdata;
  logic        h_waitreq;
  logic [AW-1:0] m_addr;
  logic        m_write, m_read;
  logic [63:0] m_wdata;
  logic [63:0] m_rdata = '0;
  logic        m_waitreq = 1'b1, m_rvalid = 1'b0;

  int n_chk = 0, n_fail = 0, stalls = 0, wr_cnt = 0, cyc = 0;
  logic [63:0] mem [IMG];
  logic [63:0] img [IMG];
  int rd_wait = 0, rd_idx = 0;
  logic prev_hold = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [63:0] prev_data;

  always #2 clk = ~clk;

  cart_xfer_bridge #(.HOST_DW(32), .MEM_AW(AW), .IMG_WORDS(IMG)) u_dut (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] stat(input logic b, input logic d, input logic e);
    return {29'd0, e, d, b};
  endfunction

  // memory model: all activity at the falling edge
  always @(negedge clk) begin
    m_rvalid = 1'b0;
    if (rd_wait > 0) begin
      rd_wait--;
      if (rd_wait == 0) begin
        m_rvalid = 1'b1;
        m_rdata  = mem[rd_idx];
      end
    end
    if (prev_hold)  // R9 stability while held off
      chk(m_write && m_addr == prev_addr && m_wdata == prev_data, "R9",
          {54'd0, m_addr}, {54'd0, prev_addr});
    chk(!(m_write && m_read), "R9", {63'd0, m_read}, 64'd0);
    m_waitreq = ($urandom % 2) == 0;
    prev_hold = m_write && m_waitreq;
    prev_addr = m_addr;
    prev_data = m_wdata;
    if (m_write || m_read)
      chk(int'(m_addr) >= BASE, "R5", {54'd0, m_addr}, 64'(BASE));
    if (m_write && !m_waitreq) begin
      mem[int'(m_addr) - BASE] = m_wdata;
      wr_cnt++;
    end
    if (m_read && !m_waitreq) begin
      rd_idx  = int'(m_addr) - BASE;
      rd_wait = 1 + ($urandom % 3);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  task automatic hwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    h_waddr = a; h_wdata = d; h_write = 1'b1;
    #1;
    while (h_waitreq) begin stalls++; @(negedge clk); #1; end
    @(posedge clk); #0.5;
    h_write = 1'b0;
  endtask

  task automatic hread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    h_waddr = a; h_read = 1'b1;
    #1;
    while (h_waitreq) begin stalls++; @(negedge clk); #1; end
    d = h_rdata;
    @(posedge clk); #0.5;
    h_read = 1'b0;
  endtask

  task automatic wait_done(output logic [31:0] s);
    for (int i = 0; i < 60; i++) begin
      hread(2'd0, s);
      if (s[1]) break;
    end
  endtask

  logic [31:0] r;
  int wc0;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(!m_write && !m_read, "R10", {62'd0, m_write, m_read}, 64'd0);
    rst_n = 1'b1;
    hread(2'd0, r);
    chk(r == 32'd0, "R10", {32'd0, r}, 64'd0);
    hwrite(2'd1, 32'hFFFF_FFFF);
    hread(2'd1, r);
    chk(r == 32'd0, "R1", {32'd0, r}, 64'd0);
    hread(2'd0, r);
    chk(r == 32'd0, "R1", {32'd0, r}, 64'd0);

    // load (R3, R6, R7), data slots 2 and 3 alternated
    for (int i = 0; i < IMG; i++) img[i] = {$urandom, $urandom};
    wc0 = wr_cnt;
    hwrite(2'd0, 32'd1);
    hread(2'd0, r);
    chk(r == stat(1, 0, 0), "R2", {32'd0, r}, {32'd0, stat(1, 0, 0)});
    for (int i = 0; i < IMG; i++) begin
      hwrite(2'd2, img[i][31:0]);
      hwrite(2'd3, img[i][63:32]);
      if (i == IMG - 1) begin
        hread(2'd0, r);
        chk(r == stat(1, 0, 0), "R6", {32'd0, r}, {32'd0, stat(1, 0, 0)});
      end
    end
    wait_done(r);
    chk(r == stat(0, 1, 0), "R6", {32'd0, r}, {32'd0, stat(0, 1, 0)});
    chk(wr_cnt - wc0 == IMG, "R3", 64'(wr_cnt - wc0), 64'(IMG));
    for (int i = 0; i < IMG; i++)
      chk(mem[i] == img[i], "R3", mem[i], img[i]);
    chk(stalls > 0, "R7", 64'(stalls), 64'd1);

    // unload (R4, R6)
    for (int i = 0; i < IMG; i++) mem[i] = {$urandom, $urandom};
    hwrite(2'd0, 32'd2);
    for (int i = 0; i < IMG; i++) begin
      hread(2'd3, r);
      chk(r == mem[i][31:0], "R4", {32'd0, r}, {32'd0, mem[i][31:0]});
      if (i == IMG - 1) begin
        hread(2'd0, r);
        chk(r == stat(1, 0, 0), "R6", {32'd0, r}, {32'd0, stat(1, 0, 0)});
      end
      hread(2'd2, r);
      chk(r == mem[i][63:32], "R4", {32'd0, r}, {32'd0, mem[i][63:32]});
    end
    hread(2'd0, r);
    chk(r == stat(0, 1, 0), "R6", {32'd0, r}, {32'd0, stat(0, 1, 0)});

    // idle data access (R8)
    wc0 = wr_cnt;
    hwrite(2'd2, 32'hDEAD_BEEF);
    hwrite(2'd3, 32'hCAFE_F00D);
    repeat (10) @(negedge clk);
    chk(wr_cnt == wc0, "R8", 64'(wr_cnt), 64'(wc0));
    hread(2'd2, r);
    chk(r == 32'd0, "R8", {32'd0, r}, 64'd0);
    hread(2'd0, r);
    chk(r == stat(0, 1, 1), "R8", {32'd0, r}, {32'd0, stat(0, 1, 1)});

    // command 0 has no effect, then abort with half a pair buffered (R2)
    hwrite(2'd0, 32'd0);
    hread(2'd0, r);
    chk(r == stat(0, 1, 1), "R2", {32'd0, r}, {32'd0, stat(0, 1, 1)});
    hwrite(2'd0, 32'd1);
    hread(2'd0, r);
    chk(r == stat(1, 0, 0), "R2", {32'd0, r}, {32'd0, stat(1, 0, 0)});
    hwrite(2'd2, 32'h1111_1111);
    hwrite(2'd2, 32'h2222_2222);
    hwrite(2'd2, 32'h3333_3333);
    repeat (8) @(negedge clk);
    hwrite(2'd0, 32'd3);
    hread(2'd0, r);
    chk(r == stat(0, 0, 0), "R2", {32'd0, r}, 64'd0);

    // restart must begin at base with phase cleared (R2, R5)
    for (int i = 0; i < IMG; i++) img[i] = {$urandom, $urandom};
    hwrite(2'd0, 32'd1);
    for (int i = 0; i < IMG; i++) begin
      hwrite(2'd3, img[i][31:0]);
      hwrite(2'd2, img[i][63:32]);
    end
    wait_done(r);
    chk(r == stat(0, 1, 0), "R6", {32'd0, r}, {32'd0, stat(0, 1, 0)});
    chk(mem[0] == img[0], "R2", mem[0], img[0]);
    for (int i = 1; i < IMG; i++)
      chk(mem[i] == img[i], "R5", mem[i], img[i]);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule